// File: doc/BRIEF.md
# Split-Tenure Processor Bus Arbiter

This block hands out ownership of a pipelined processor bus on which the address phase and the data phase of a transaction are separate tenures. Each master has three dedicated wires: a bus request, an address-bus grant and a data-bus grant. Every other bus signal is shared: transfer start, burst flag, address acknowledge, address retry and transfer acknowledge. Up to four processors can be attached. A build option adds one more master slot for an external cache controller, which competes on equal terms with the processors.

An address grant goes to one requester at a time, chosen by rotating priority. The grant stays up until that master starts its transfer. The address tenure closes on address acknowledge. In the following cycle the retry input decides whether the tenure is thrown away or accepted. Accepted tenures enter a short in-order queue. The data side pops that queue and grants the data bus to one master at a time. It counts one beat for a single transfer and four for a burst, and releases the grant after the final beat. Because the two sides are independent, the next address tenure can run while an earlier data tenure is still in progress.

Top module: `splitbus_arb`

## Requirements
- R1: While reset is asserted and directly after it is released, every address grant and every data grant is low.
- R2: Master k uses bit k of `bus_req`, `addr_grant` and `data_grant`. When `EXT_EN` is 1, the cache controller sits at index `N_PROC`. At most one address grant is high at a time. The winner is the first requesting index at or after a rotating pointer, searched upward with wraparound. The pointer starts at 0 and moves to one past the winner after each accepted tenure.
- R3: A request seen while the address side is idle and the queue is not full raises that master's address grant one cycle later. The grant stays high while `xfer_start` is low. It drops in the cycle after `xfer_start` is sampled high.
- R4: The address tenure ends on `addr_ack`, and `addr_retry` is sampled in the next cycle. A retried tenure is discarded: it causes no data grant, and the rotating pointer does not move, so the same master wins again if it still requests.
- R5: Each accepted tenure is queued, and data grants follow the order of the queue. When the data bus is free, the data grant rises in the cycle after the tenure is accepted.
- R6: A tenure started with `xfer_burst` high takes four beats; otherwise it takes one beat. Each `xfer_ack` during a data grant ends one beat, and the grant is low in the cycle after the final beat.
- R7: At most one data grant is high at a time. Two successive data grants are separated by at least one cycle with no data grant.
- R8: An address grant can be issued while a data grant from an earlier tenure is still high.
- R9: The queue holds two accepted tenures. While it is full, no new address grant is issued. Granting resumes in the cycle after a data tenure completes.
- R10: An acceptance and a final beat in the same cycle both take effect. The accepted tenure is granted the data bus once the current grant has dropped.
- R11: With `EXT_EN` set, the cache-controller slot wins, is retried and is served exactly like a processor slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | N_PROC+EXT_EN | One request per master |
| xfer_start | input | 1 | Shared transfer start from the granted master |
| xfer_burst | input | 1 | Burst flag, valid with transfer start |
| addr_ack | input | 1 | Shared address acknowledge |
| addr_retry | input | 1 | Shared address retry, sampled the cycle after acknowledge |
| xfer_ack | input | 1 | Shared transfer acknowledge, one per data beat |
| addr_grant | output | N_PROC+EXT_EN | Address-bus grant per master |
| data_grant | output | N_PROC+EXT_EN | Data-bus grant per master |

## Verification
Two events can land on the same clock edge: the address side accepting a tenure after the retry cycle, and the data side retiring its last beat. The bench places the final transfer acknowledge of a single-beat tenure on the exact edge where a second master's burst tenure is accepted. It then checks that the first data grant drops, that one idle cycle follows, and that the second master then holds the data grant for exactly four beats. A second directed case fills the queue and checks that address granting stalls and then resumes in the cycle after a pop.

// File: rtl/sba_pkg.sv
package sba_pkg;
   typedef enum logic [1:0] {
      A_IDLE   = 2'd0,
      A_GRANT  = 2'd1,
      A_TENURE = 2'd2,
      A_CHECK  = 2'd3
   } addr_st_e;
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
   parameter int N  = 5,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] ptr,
   output logic          any,
   output logic [IW-1:0] win
);
   // Scan from the farthest offset down to the nearest, so the nearest requester wins.
   always_comb begin
      any = 1'b0;
      win = '0;
      for (int off = N - 1; off >= 0; off--) begin
         int idx;
         idx = (int'(ptr) + off) % N;
         if (req[IW'(idx)]) begin
            any = 1'b1;
            win = IW'(idx);
         end
      end
   end
endmodule

// File: rtl/sba_order_fifo.sv
module sba_order_fifo #(
   parameter int W     = 4,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= nxt(wp);
         if (pop)  rp <= nxt(rp);
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/splitbus_arb.sv
module splitbus_arb
   import sba_pkg::*;
#(
   parameter int N_PROC      = 4,
   parameter int EXT_EN      = 1,
   parameter int BURST_BEATS = 4,
   parameter int Q_DEPTH     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_PROC+EXT_EN-1:0]   bus_req,
   input  logic                       xfer_start,
   input  logic                       xfer_burst,
   input  logic                       addr_ack,
   input  logic                       addr_retry,
   input  logic                       xfer_ack,
   output logic [N_PROC+EXT_EN-1:0]   addr_grant,
   output logic [N_PROC+EXT_EN-1:0]   data_grant
);
   localparam int NM = N_PROC + EXT_EN;
   localparam int IW = (NM > 1) ? $clog2(NM) : 1;
   localparam int BW = $clog2(BURST_BEATS + 1);
   localparam int EW = IW + 1;

   if (N_PROC < 1 || N_PROC > 4) begin : g_bad_nproc
      $error("N_PROC must be 1..4");
   end
   if (EXT_EN != 0 && EXT_EN != 1) begin : g_bad_ext
      $error("EXT_EN must be 0 or 1");
   end
   if (BURST_BEATS < 2) begin : g_bad_beats
      $error("BURST_BEATS must be at least 2");
   end
   if (Q_DEPTH < 2) begin : g_bad_depth
      $error("Q_DEPTH must be at least 2");
   end

   // Address side
   addr_st_e      a_st;
   logic [IW-1:0] a_who;
   logic          a_burst;
   logic [IW-1:0] rr_ptr;
   logic          pick_any;
   logic [IW-1:0] pick_win;

   logic          q_push, q_pop, q_empty, q_full;
   logic [EW-1:0] q_head;

   sba_rr_pick #(.N(NM), .IW(IW)) u_pick (
      .req (bus_req),
      .ptr (rr_ptr),
      .any (pick_any),
      .win (pick_win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_st    <= A_IDLE;
         a_who   <= '0;
         a_burst <= 1'b0;
         rr_ptr  <= '0;
      end else begin
         case (a_st)
            A_IDLE: if (pick_any && !q_full) begin
               a_st  <= A_GRANT;
               a_who <= pick_win;
            end
            A_GRANT: if (xfer_start) begin
               a_st    <= A_TENURE;
               a_burst <= xfer_burst;
            end
            A_TENURE: if (addr_ack) a_st <= A_CHECK;
            A_CHECK: begin
               a_st <= A_IDLE;
               if (!addr_retry)
                  rr_ptr <= (a_who == IW'(NM - 1)) ? '0 : a_who + 1'b1;
            end
            default: a_st <= A_IDLE;
         endcase
      end
   end

   assign q_push = (a_st == A_CHECK) && !addr_retry;

   sba_order_fifo #(.W(EW), .DEPTH(Q_DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   ({a_burst, a_who}),
      .pop   (q_pop),
      .dout  (q_head),
      .empty (q_empty),
      .full  (q_full)
   );

   // Data side
   logic          d_busy;
   logic [IW-1:0] d_who;
   logic [BW-1:0] d_left;

   assign q_pop = d_busy && xfer_ack && (d_left == BW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_busy <= 1'b0;
         d_who  <= '0;
         d_left <= '0;
      end else if (!d_busy) begin
         if (!q_empty) begin
            d_busy <= 1'b1;
            d_who  <= q_head[IW-1:0];
            d_left <= q_head[IW] ? BW'(BURST_BEATS) : BW'(1);
         end
      end else if (xfer_ack) begin
         if (d_left == BW'(1)) d_busy <= 1'b0;
         d_left <= d_left - BW'(1);
      end
   end

   for (genvar m = 0; m < NM; m++) begin : g_grant
      assign addr_grant[m] = (a_st == A_GRANT) && (a_who == IW'(m));
      assign data_grant[m] = d_busy && (d_who == IW'(m));
   end

   p_one_abg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(addr_grant));
   p_one_dbg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(data_grant));
   p_abg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|addr_grant) && !xfer_start) |=> (addr_grant == $past(addr_grant)));
   p_abg_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|addr_grant) && xfer_start) |=> (addr_grant == '0));
   p_dbg_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|data_grant) && xfer_ack && d_left == BW'(1)) |=> (data_grant == '0));
   p_retry_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_st == A_CHECK && addr_retry) |=> $stable(rr_ptr));
endmodule

// File: tb/sim_splitbus_arb.sv
module sim_splitbus_arb;
   localparam int NM = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NM-1:0] req = '0;
   logic          ts = 1'b0, tbst = 1'b0, aack = 1'b0, artry = 1'b0, ta = 1'b0;
   logic [NM-1:0] abg, dbg;
   int            total = 0;
   int            bad = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   splitbus_arb #(.N_PROC(4), .EXT_EN(1), .BURST_BEATS(4), .Q_DEPTH(2)) u0 (
      .clk (clk), .rst_n (rst_n), .bus_req (req),
      .xfer_start (ts), .xfer_burst (tbst), .addr_ack (aack),
      .addr_retry (artry), .xfer_ack (ta),
      .addr_grant (abg), .data_grant (dbg)
   );

   // row: {req[4:0], burst, retry, expected winner[2:0]}
   localparam logic [9:0] VEC [9] = '{
      {5'b00001, 1'b0, 1'b0, 3'd0},
      {5'b11111, 1'b1, 1'b0, 3'd1},
      {5'b00011, 1'b0, 1'b0, 3'd0},
      {5'b10001, 1'b1, 1'b1, 3'd4},
      {5'b10001, 1'b0, 1'b0, 3'd4},
      {5'b01000, 1'b1, 1'b0, 3'd3},
      {5'b00110, 1'b0, 1'b0, 3'd1},
      {5'b11110, 1'b0, 1'b1, 3'd2},
      {5'b11110, 1'b0, 1'b0, 3'd2}
   };

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [NM-1:0] got, input logic [NM-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic run_row(input logic [9:0] v);
      logic [NM-1:0] r;
      logic          bu, rt;
      logic [NM-1:0] w;
      r  = v[9:5];
      bu = v[4];
      rt = v[3];
      w  = NM'(1) << v[2:0];
      req = r;
      tick;
      chk("R2 round-robin winner", abg, w);
      tick;
      chk("R3 grant held before start", abg, w);
      ts = 1'b1; tbst = bu;
      tick;
      ts = 1'b0; tbst = 1'b0;
      chk("R3 grant dropped after start", abg, '0);
      aack = 1'b1;
      tick;
      aack = 1'b0; artry = rt;
      tick;
      artry = 1'b0; req = '0;
      tick;
      if (rt) begin
         chk("R4 retried tenure gets no data grant", dbg, '0);
      end else begin
         chk("R5 data grant after accept", dbg, w);
         for (int b = 1; b <= (bu ? 4 : 1); b++) begin
            ta = 1'b1;
            tick;
            ta = 1'b0;
            if (b == (bu ? 4 : 1)) chk("R6 data grant off after final beat", dbg, '0);
            else                   chk("R6 data grant kept mid burst", dbg, w);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 address grants in reset", abg, '0);
      chk("R1 data grants in reset", dbg, '0);
      rst_n = 1'b1;
      chk("R1 address grants after reset", abg, '0);
      tick;
      chk("R1 data grants after reset", dbg, '0);

      // table walk: R2 R3 R4 R5 R6, rows 4 and 5 exercise the cache slot (R11)
      foreach (VEC[i]) run_row(VEC[i]);

      // R8 and R10: pipelined address tenure; accept and final beat on one edge
      req = 5'b00011;
      tick;
      chk("R2 master 0 wins from pointer 3", abg, 5'b00001);
      ts = 1'b1; tbst = 1'b0;
      tick;
      ts = 1'b0; aack = 1'b1;
      tick;
      aack = 1'b0;
      tick;
      req = 5'b00010;
      tick;
      chk("R8 address grant during data tenure", abg, 5'b00010);
      chk("R8 data grant to master 0", dbg, 5'b00001);
      ts = 1'b1; tbst = 1'b1;
      tick;
      ts = 1'b0; tbst = 1'b0; aack = 1'b1;
      tick;
      aack = 1'b0; ta = 1'b1;
      tick;
      ta = 1'b0; req = '0;
      chk("R10 first data grant released", dbg, '0);
      tick;
      chk("R10 R7 accepted tenure granted after gap", dbg, 5'b00010);
      for (int b = 1; b <= 4; b++) begin
         ta = 1'b1;
         tick;
         ta = 1'b0;
         chk("R6 R10 burst beats", dbg, (b == 4) ? 5'b00000 : 5'b00010);
      end

      // R9: queue full blocks address grants
      req = 5'b01100;
      tick;
      chk("R2 master 2 wins", abg, 5'b00100);
      ts = 1'b1;
      tick;
      ts = 1'b0; aack = 1'b1;
      tick;
      aack = 1'b0;
      tick;
      req = 5'b01000;
      tick;
      chk("R9 second grant while one queued", abg, 5'b01000);
      ts = 1'b1; tbst = 1'b1;
      tick;
      ts = 1'b0; tbst = 1'b0; aack = 1'b1;
      tick;
      aack = 1'b0;
      tick;
      req = 5'b00001;
      tick;
      tick;
      chk("R9 no grant while queue full", abg, '0);
      chk("R7 data grant to master 2", dbg, 5'b00100);
      ta = 1'b1;
      tick;
      ta = 1'b0;
      chk("R9 still no grant on pop edge", abg, '0);
      tick;
      chk("R9 grant resumes after pop", abg, 5'b00001);
      chk("R5 next queued data grant", dbg, 5'b01000);
      ts = 1'b1;
      tick;
      ts = 1'b0; aack = 1'b1;
      tick;
      aack = 1'b0; artry = 1'b1;
      tick;
      artry = 1'b0; req = '0;
      for (int b = 1; b <= 4; b++) begin
         ta = 1'b1;
         tick;
         ta = 1'b0;
      end
      chk("R4 R6 bus drained", dbg, '0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule